// File: doc/BRIEF.md
# Bus Byte-Parity Checker and Generator

This block sits between a 36-bit data port and its pads. It checks parity on the incoming bus and can insert parity into the outgoing word. The word is four 9-bit lanes: bits [8:0], [17:9], [26:18] and [35:27]. In each lane the top bit carries parity for the eight bits below it. One select input sets the parity type, odd or even, for both checking and generation.

Two ports are served, each with its own set of control strobes and its own parity tree.

- **Checking.** Each port's tree normally watches the incoming bus. It drives an active-low error flag, which is registered on the port clock.
- **Port B generation.** When its generate enable is high, port B can overwrite the lane top bits with generated parity on FIFO data reads.
- **Mailbox generation.** Either port does the same on mailbox register reads.

A mailbox read with generation borrows the port's tree to compute the outgoing parity. During such a read the error flag is held inactive, whatever the bus carries. The FIFO storage and the tri-state pad drivers live outside this block.

Top module: `bus_parity_unit`

## Requirements
- R1: Generation touches only bit 8 of each 9-bit lane (bits 8, 17, 26, 35). The low eight bits of every lane of the output word always equal the read word.
- R2: While `rst` is high at a rising clock edge, both error flags are driven high (inactive) after that edge, whatever the bus holds.
- R3: In any cycle that is not a forced cycle (R8), the error flag after a rising edge is low if any of the four lanes sampled on that edge fails parity. It is high if all four pass.
- R4: With `odd_sel` high, a lane passes when its nine bits hold an odd number of ones. With `odd_sel` low, it passes when it holds an even number. This holds both for checking and for the lanes that generation produces.
- R5: On port B, a FIFO data read with generation enabled replaces each lane's bit 8 with generated parity. Such a read has `sel_n`=0, `strobe`=1, `write`=0, `mbox`=0 and `gen`=1.
- R6: On either port, a mailbox read with generation enabled replaces each lane's bit 8 with generated parity. Such a read has `sel_n`=0, `strobe`=1, `write`=0, `mbox`=1 and `gen`=1.
- R7: In every other case the output word equals the read word unchanged. This covers `gen` low, any cycle that is not a read, and FIFO reads on port A.
- R8: During a mailbox read with generation (the R6 strobe pattern), the error flag after the edge is high whatever the bus holds.
- R9: If any one of the five R8 conditions is missing, including `strobe` low, the flag checks the bus as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | 1 selects odd parity, 0 even, for both ports |
| a_sel_n | input | 1 | Port A select, active low |
| a_strobe | input | 1 | Port A access enable |
| a_write | input | 1 | Port A direction, 1 write, 0 read |
| a_mbox | input | 1 | Port A mailbox select |
| a_gen | input | 1 | Port A parity generation enable |
| a_bus_in | input | 36 | Port A value seen on the pads |
| a_rd_word | input | 36 | Word port A is about to drive out |
| a_word_out | output | 36 | Port A outgoing word after parity insertion |
| a_err_n | output | 1 | Port A parity error flag, active low |
| b_sel_n | input | 1 | Port B select, active low |
| b_strobe | input | 1 | Port B access enable |
| b_write | input | 1 | Port B direction, 1 write, 0 read |
| b_mbox | input | 1 | Port B mailbox select |
| b_gen | input | 1 | Port B parity generation enable |
| b_bus_in | input | 36 | Port B value seen on the pads |
| b_rd_word | input | 36 | Word port B is about to drive out |
| b_word_out | output | 36 | Port B outgoing word after parity insertion |
| b_err_n | output | 1 | Port B parity error flag, active low |

## Verification
The bench sweeps all 32 strobe combinations on each port, both parity types and every pattern of failing lanes. This exercises the corners:

- **Forced cycle.** The force must hold only when all five mailbox-read conditions are present. A design that forced the flag on any mailbox read, ignoring `strobe`, would show a missed error when `strobe` is low. One that never forced would report spurious errors during generated mailbox reads.
- **FIFO reads on port A.** A port A FIFO read must pass through untouched. Wrongly applying port B's FIFO generation there would corrupt bit 8 of A's output lanes.
- **Parity sense and lane placement.** An inverted parity sense or a misplaced lane boundary shows up as a wrong top bit, or a wrong flag, in one lane of the mask sweep.
- **Reset.** The bench asserts reset while a bad bus is present and checks that the flag is held inactive.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    parameter int unsigned LANE_W_DEF = 9;
    parameter int unsigned LANES_DEF  = 4;

    // decoded port strobes
    typedef struct packed {
        logic sel_n;
        logic strobe;
        logic write;
        logic mbox;
        logic gen;
    } port_ctl_t;

    // which source feeds the top bit of each outgoing lane
    typedef enum logic [1:0] {
        SRC_PASS = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_MBOX = 2'd2
    } top_src_e;

    function automatic logic is_read(input port_ctl_t c);
        return !c.sel_n && c.strobe && !c.write;
    endfunction

endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
    parameter int unsigned LANES  = bpar_pkg::LANES_DEF,
    parameter int unsigned LANE_W = bpar_pkg::LANE_W_DEF,
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANES-1:0]  top_in,
    input  logic              odd_sel,
    output logic [LANES-1:0]  gen_bits,
    output logic [LANES-1:0]  fails
);
    // one xor reduction per lane serves both generation and checking
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic low_x;
        assign low_x       = ^word[l*LANE_W +: LANE_W-1];
        assign gen_bits[l] = low_x ^ odd_sel;
        assign fails[l]    = low_x ^ top_in[l] ^ odd_sel;
    end

endmodule

// File: rtl/parity_insert.sv
module parity_insert #(
    parameter int unsigned LANES  = bpar_pkg::LANES_DEF,
    parameter int unsigned LANE_W = bpar_pkg::LANE_W_DEF,
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0]  word_in,
    input  logic [LANES-1:0]   fifo_bits,
    input  logic [LANES-1:0]   mbox_bits,
    input  bpar_pkg::top_src_e src,
    output logic [WORD_W-1:0]  word_out
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int unsigned TOP = l*LANE_W + LANE_W - 1;
        assign word_out[l*LANE_W +: LANE_W-1] = word_in[l*LANE_W +: LANE_W-1];
        always_comb begin
            unique case (src)
                bpar_pkg::SRC_FIFO: word_out[TOP] = fifo_bits[l];
                bpar_pkg::SRC_MBOX: word_out[TOP] = mbox_bits[l];
                default:            word_out[TOP] = word_in[TOP];
            endcase
        end
    end

endmodule

// File: rtl/bpar_port.sv
module bpar_port
    import bpar_pkg::*;
#(
    parameter int unsigned LANES    = LANES_DEF,
    parameter int unsigned LANE_W   = LANE_W_DEF,
    parameter bit          FIFO_GEN = 1'b0,
    localparam int unsigned WORD_W  = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              odd_sel,
    input  port_ctl_t         ctl,
    input  logic [WORD_W-1:0] bus_in,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] word_out,
    output logic              err_n
);
    logic              mbox_gen;
    logic              fifo_gen;
    top_src_e          src;
    logic [WORD_W-1:0] tree_word;
    logic [LANES-1:0]  tree_top;
    logic [LANES-1:0]  tree_gen;
    logic [LANES-1:0]  tree_fail;
    logic [LANES-1:0]  fifo_bits;
    logic              err_q;

    assign mbox_gen = is_read(ctl) && ctl.mbox && ctl.gen;
    assign fifo_gen = FIFO_GEN && is_read(ctl) && !ctl.mbox && ctl.gen;

    always_comb begin
        if (mbox_gen)      src = SRC_MBOX;
        else if (fifo_gen) src = SRC_FIFO;
        else               src = SRC_PASS;
    end

    // the shared tree looks at the outgoing word only while a mailbox read borrows it
    assign tree_word = mbox_gen ? rd_word : bus_in;
    for (genvar l = 0; l < LANES; l++) begin : g_top
        assign tree_top[l] = tree_word[l*LANE_W + LANE_W - 1];
    end

    parity_tree #(.LANES(LANES), .LANE_W(LANE_W)) u_tree (
        .word    (tree_word),
        .top_in  (tree_top),
        .odd_sel (odd_sel),
        .gen_bits(tree_gen),
        .fails   (tree_fail)
    );

    if (FIFO_GEN) begin : g_fifo_gen
        logic [LANES-1:0] unused_fail;
        logic [LANES-1:0] rd_top;
        for (genvar l = 0; l < LANES; l++) begin : g_rt
            assign rd_top[l] = rd_word[l*LANE_W + LANE_W - 1];
        end
        parity_tree #(.LANES(LANES), .LANE_W(LANE_W)) u_out_tree (
            .word    (rd_word),
            .top_in  (rd_top),
            .odd_sel (odd_sel),
            .gen_bits(fifo_bits),
            .fails   (unused_fail)
        );
    end else begin : g_no_fifo_gen
        assign fifo_bits = '0;
    end

    parity_insert #(.LANES(LANES), .LANE_W(LANE_W)) u_insert (
        .word_in  (rd_word),
        .fifo_bits(fifo_bits),
        .mbox_bits(tree_gen),
        .src      (src),
        .word_out (word_out)
    );

    always_ff @(posedge clk) begin
        if (rst)           err_q <= 1'b1;
        else if (mbox_gen) err_q <= 1'b1;
        else               err_q <= ~|tree_fail;
    end
    assign err_n = err_q;

    // ---------------- assertions ----------------
    function automatic logic word_bad(input logic [WORD_W-1:0] w, input logic odd);
        logic bad;
        bad = 1'b0;
        for (int l = 0; l < int'(LANES); l++) begin
            if (($countones(w[l*LANE_W +: LANE_W]) % 2 == 1) != odd) bad = 1'b1;
        end
        return bad;
    endfunction

    function automatic logic lows_match(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
        logic ok;
        ok = 1'b1;
        for (int l = 0; l < int'(LANES); l++) begin
            if (a[l*LANE_W +: LANE_W-1] != b[l*LANE_W +: LANE_W-1]) ok = 1'b0;
        end
        return ok;
    endfunction

    logic force_cond;
    logic gen_cond;
    assign force_cond = !ctl.sel_n && ctl.strobe && !ctl.write && ctl.mbox && ctl.gen;
    assign gen_cond   = !ctl.sel_n && ctl.strobe && !ctl.write && ctl.gen && (ctl.mbox || FIFO_GEN);

    assert_force_high_R8: assert property (@(posedge clk) disable iff (rst)
        force_cond |=> err_n);

    assert_check_bus_R3: assert property (@(posedge clk) disable iff (rst)
        !force_cond |=> (err_n == !word_bad($past(bus_in), $past(odd_sel))));

    assert_gen_type_R4: assert property (@(posedge clk) disable iff (rst)
        gen_cond |-> !word_bad(word_out, odd_sel));

    assert_pass_through_R7: assert property (@(posedge clk) disable iff (rst)
        !gen_cond |-> (word_out == rd_word));

    assert_low_bits_R1: assert property (@(posedge clk) disable iff (rst)
        lows_match(word_out, rd_word));

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bpar_pkg::*;
#(
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              odd_sel,
    input  logic              a_sel_n,
    input  logic              a_strobe,
    input  logic              a_write,
    input  logic              a_mbox,
    input  logic              a_gen,
    input  logic [WORD_W-1:0] a_bus_in,
    input  logic [WORD_W-1:0] a_rd_word,
    output logic [WORD_W-1:0] a_word_out,
    output logic              a_err_n,
    input  logic              b_sel_n,
    input  logic              b_strobe,
    input  logic              b_write,
    input  logic              b_mbox,
    input  logic              b_gen,
    input  logic [WORD_W-1:0] b_bus_in,
    input  logic [WORD_W-1:0] b_rd_word,
    output logic [WORD_W-1:0] b_word_out,
    output logic              b_err_n
);
    port_ctl_t a_ctl;
    port_ctl_t b_ctl;

    assign a_ctl = '{sel_n: a_sel_n, strobe: a_strobe, write: a_write, mbox: a_mbox, gen: a_gen};
    assign b_ctl = '{sel_n: b_sel_n, strobe: b_strobe, write: b_write, mbox: b_mbox, gen: b_gen};

    // port A generates only for mailbox reads
    bpar_port #(.LANES(LANES), .LANE_W(LANE_W), .FIFO_GEN(1'b0)) u_port_a (
        .clk     (clk),
        .rst     (rst),
        .odd_sel (odd_sel),
        .ctl     (a_ctl),
        .bus_in  (a_bus_in),
        .rd_word (a_rd_word),
        .word_out(a_word_out),
        .err_n   (a_err_n)
    );

    // port B generates for FIFO and mailbox reads
    bpar_port #(.LANES(LANES), .LANE_W(LANE_W), .FIFO_GEN(1'b1)) u_port_b (
        .clk     (clk),
        .rst     (rst),
        .odd_sel (odd_sel),
        .ctl     (b_ctl),
        .bus_in  (b_bus_in),
        .rd_word (b_rd_word),
        .word_out(b_word_out),
        .err_n   (b_err_n)
    );

endmodule

// File: tb/sim_bus_parity_unit.sv
`timescale 1ns/1ps
module sim_bus_parity_unit;

    localparam int LW = 9;
    localparam int NL = 4;
    localparam int W  = LW * NL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic odd_sel = 1'b0;
    logic a_sel_n = 1'b1, a_strobe = 1'b0, a_write = 1'b0, a_mbox = 1'b0, a_gen = 1'b0;
    logic b_sel_n = 1'b1, b_strobe = 1'b0, b_write = 1'b0, b_mbox = 1'b0, b_gen = 1'b0;
    logic [W-1:0] a_bus_in = '0, a_rd_word = '0, b_bus_in = '0, b_rd_word = '0;
    logic [W-1:0] a_word_out, b_word_out;
    logic a_err_n, b_err_n;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    bus_parity_unit u0 (
        .clk(clk), .rst(rst), .odd_sel(odd_sel),
        .a_sel_n(a_sel_n), .a_strobe(a_strobe), .a_write(a_write), .a_mbox(a_mbox), .a_gen(a_gen),
        .a_bus_in(a_bus_in), .a_rd_word(a_rd_word), .a_word_out(a_word_out), .a_err_n(a_err_n),
        .b_sel_n(b_sel_n), .b_strobe(b_strobe), .b_write(b_write), .b_mbox(b_mbox), .b_gen(b_gen),
        .b_bus_in(b_bus_in), .b_rd_word(b_rd_word), .b_word_out(b_word_out), .b_err_n(b_err_n)
    );

    function automatic int ones(input logic [LW-1:0] v);
        int n = 0;
        for (int i = 0; i < LW; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bus with lanes in fail_mask deliberately wrong for the chosen parity type
    function automatic logic [W-1:0] make_bus(input logic [31:0] s, input logic odd, input logic [NL-1:0] fail_mask);
        logic [W-1:0] w;
        logic [31:0] r = s;
        for (int l = 0; l < NL; l++) begin
            logic [7:0] low;
            logic top;
            r = next_rand(r);
            low = r[23:16];
            top = ((ones({1'b0, low}) % 2) == 1) ? !odd : odd;
            if (fail_mask[l]) top = !top;
            w[l*LW +: LW] = {top, low};
        end
        return w;
    endfunction

    task automatic run_vec(input int port, input logic [4:0] c, input logic odd, input logic [NL-1:0] mask);
        logic [W-1:0] bus, rd, exp_word, act_word;
        logic rd_op, gen_on, frc, exp_err, act_err;
        string tag;
        seed = next_rand(seed);
        bus = make_bus(seed, odd, mask);
        seed = next_rand(seed);
        rd = {seed[3:0], seed, ~seed};
        odd_sel = odd;
        if (port == 0) begin
            {a_sel_n, a_strobe, a_write, a_mbox, a_gen} = c;
            a_bus_in = bus; a_rd_word = rd;
            {b_sel_n, b_strobe, b_write, b_mbox, b_gen} = 5'b10000;
        end else begin
            {b_sel_n, b_strobe, b_write, b_mbox, b_gen} = c;
            b_bus_in = bus; b_rd_word = rd;
            {a_sel_n, a_strobe, a_write, a_mbox, a_gen} = 5'b10000;
        end
        rd_op  = !c[4] && c[3] && !c[2];
        gen_on = rd_op && c[0] && (c[1] || port == 1);
        frc    = rd_op && c[1] && c[0];
        exp_word = rd;
        if (gen_on) begin
            for (int l = 0; l < NL; l++) begin
                logic p;
                p = (ones({1'b0, rd[l*LW +: 8]}) % 2) == 1;
                exp_word[l*LW + 8] = odd ? !p : p;
            end
        end
        #2;
        act_word = (port == 0) ? a_word_out : b_word_out;
        // R5 / R6 / R7: outgoing word, R1 lows untouched
        tag = !gen_on ? "R7" : (c[1] ? "R6" : "R5");
        check(tag, act_word, exp_word);
        if (gen_on) begin
            logic [W-1:0] ok_lanes;
            ok_lanes = '0;
            // R4: every generated lane has the selected count type
            for (int l = 0; l < NL; l++)
                ok_lanes[l] = ((ones(act_word[l*LW +: LW]) % 2) == 1) == odd;
            check("R4", ok_lanes, {{(W-NL){1'b0}}, {NL{1'b1}}});
        end
        check("R1", act_word & {NL{9'h0FF}}, rd & {NL{9'h0FF}});
        @(negedge clk);
        exp_err = frc ? 1'b1 : (mask == 0);
        act_err = (port == 0) ? a_err_n : b_err_n;
        // R8 forced, R9 near-miss of force, R3 plain check
        if (frc) tag = "R8";
        else if (c[1] && c[0] && !c[4] && !c[2]) tag = "R9";
        else tag = "R3";
        check(tag, {{(W-1){1'b0}}, act_err}, {{(W-1){1'b0}}, exp_err});
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R2: reset with bad buses present
        a_bus_in = make_bus(32'h55, 1'b0, 4'b1111);
        b_bus_in = make_bus(32'h77, 1'b0, 4'b0101);
        @(negedge clk); @(negedge clk);
        check("R2", {{(W-2){1'b0}}, a_err_n, b_err_n}, {{(W-2){1'b0}}, 2'b11});
        rst = 1'b0;
        @(negedge clk);
        // R3: bad bus now reported on both ports
        check("R3", {{(W-2){1'b0}}, a_err_n, b_err_n}, {{(W-2){1'b0}}, 2'b00});

        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 32; c++)
                for (int o = 0; o < 2; o++)
                    for (int m = 0; m < 16; m++)
                        run_vec(p, c[4:0], o[0], m[3:0]);

        // R2: reset mid-run with a failing bus on port B
        {b_sel_n, b_strobe, b_write, b_mbox, b_gen} = 5'b10000;
        odd_sel = 1'b1;
        b_bus_in = make_bus(32'h99, 1'b1, 4'b1000);
        rst = 1'b1;
        @(negedge clk);
        check("R2", {{(W-1){1'b0}}, b_err_n}, {{(W-1){1'b0}}, 1'b1});
        rst = 1'b0;
        @(negedge clk);
        check("R3", {{(W-1){1'b0}}, b_err_n}, {{(W-1){1'b0}}, 1'b0});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule